// File: doc/BRIEF.md
# Parallel Host-Bus Master for SRAM, NOR Flash and FIFO Peripherals

This block turns single-beat and burst read and write requests into cycles on an external parallel bus. The bus is the classic microcontroller kind. Requests arrive on a valid/ready handshake as a word address, a direction and a beat count. Write data is taken one beat at a time, and read data returns as a one-cycle response pulse. On the pin side the block drives the following:

- an address bus, which is used only when address and data are not shared;
- a shared address/data bus with its own output enable;
- an address latch strobe;
- four active-low chip selects;
- active-low read and write strobes;
- active-low byte-lane enables.

The strobe length is set by separate read and write wait-state counts. It can be stretched further by an external ready input. A configuration input selects a variant for FIFO peripherals, which have no address. In that variant every beat waits on the peripheral's empty or full flag. The configuration inputs are static settings. They may only change while the block is idle.

Top module: `hb_master`

## Requirements
- R1: `req_ready` is high only while no transfer is in progress, and only once reset has been released for two clock edges. A request is taken on a clock edge where both `req_valid` and `req_ready` are high.
- R2: When `cfg_mux` or `cfg_ale` is set (and `cfg_fifo` is clear), a transfer opens with exactly one address cycle. In that cycle `ale_o` is 1, `ad_oe` is 1, `ad_o` carries the full 28-bit start address and both strobes are high. `ale_o` is low in the next cycle.
- R3: With `cfg_mux` and `cfg_fifo` clear, `addr_o` carries bits 19:0 of the current beat address for the whole transfer. Otherwise, and in idle, `addr_o` is zero.
- R4: The read strobe is held low for at least `cfg_rd_ws`+1 cycles, and the write strobe for at least `cfg_wr_ws`+1 cycles. The two strobes are never low together.
- R5: Once the wait count has expired, the strobe stays low for as long as `rdy_i` is low. The beat completes at the first clock edge where the count is zero and `rdy_i` is high.
- R6: A read beat samples `ad_i` at its completing edge. In the next cycle `rsp_valid` is high for one cycle with that data, and `rsp_last` is 1 only for the final beat.
- R7: A write beat takes `req_wdata` at the edge where `wdata_take` is high, which is the edge before its strobe falls. While `wr_n_o` is low, `ad_oe` is 1 and the low data bits of `ad_o` carry that value. While `rd_n_o` is low, `ad_oe` is 0.
- R8: A burst of `req_len`+1 beats has only one address cycle. Each later beat uses the previous address plus one. There is one cycle with both strobes high between beats.
- R9: A chip select is low from the first cycle after acceptance through the last strobe cycle, and at most one is low at a time. The mode comes from `cfg_csmode`: 0 always uses select 0; 1 uses select 0 or 1 from the top address bit; 2 or 3 uses select 0 to 3 from the top two address bits. The top bit is bit 27 when `cfg_mux` is set and bit 19 otherwise. Select 0 is used when `cfg_fifo` is set.
- R10: With `cfg_fifo` set, there is no address cycle and `addr_o` is 0. In the gap cycle before each beat, a read waits while `xf_empty` is 1 and a write waits while `xf_full` is 1.
- R11: With `cfg_wide` = 1, `be_n_o` is 00 during a transfer. With `cfg_wide` = 0, `be_n_o` is 10 (only the low byte lane enabled), read data has its upper byte zeroed, and write data is driven with its upper byte zeroed. In idle `be_n_o` is 11.
- R12: While reset is asserted, every chip select and strobe is high, `ale_o` and `ad_oe` are 0, and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_mux | input | 1 | Address shared with data pins |
| cfg_ale | input | 1 | Address cycle with latch strobe in non-shared mode |
| cfg_fifo | input | 1 | Address-less FIFO peripheral variant |
| cfg_csmode | input | 2 | 0 single, 1 dual, 2/3 quad chip select |
| cfg_rd_ws | input | 4 | Read wait states |
| cfg_wr_ws | input | 4 | Write wait states |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Start word address |
| req_len | input | 4 | Beats minus one |
| req_wdata | input | 16 | Write data for the next beat |
| wdata_take | output | 1 | Current `req_wdata` consumed at this edge |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | 16 | Read data |
| rsp_last | output | 1 | Final beat of the transfer |
| addr_o | output | 20 | Separate address pins |
| ad_o | output | 28 | Shared address/data pins, output value |
| ad_oe | output | 1 | Output enable for `ad_o` |
| ad_i | input | 16 | Data pins, input value |
| ale_o | output | 1 | Address latch strobe, active high |
| cs_n_o | output | 4 | Chip selects, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| be_n_o | output | 2 | Byte-lane enables, active low |
| rdy_i | input | 1 | External ready, low stalls |
| xf_empty | input | 1 | FIFO peripheral empty flag |
| xf_full | input | 1 | FIFO peripheral full flag |

## Verification
The bound checker looks at the pins on every clock. It checks these properties:

- the address latch strobe is a single cycle and never overlaps a strobe;
- the two strobes never overlap;
- at most one chip select is low, and one is always low under a strobe;
- the bus output enable follows the strobe direction;
- a response only follows a read strobe;
- the byte-lane enables are right in 8-bit mode;
- in the FIFO variant, a strobe only falls when the relevant flag was clear in the cycle before.

The exact cycle counts are shown only by the bench's cycle-by-cycle model under its scenarios. These cover the wait-state lengths, stalls from the ready input, the address increment within a burst, the chip-select decode from the top address bits, and read data capture and masking.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int CS_N  = 4;
  localparam int CS_IW = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_PRE  = 2'd2,
    ST_STRB = 2'd3
  } hb_state_e;
endpackage

// File: rtl/hb_cs_decode.sv
module hb_cs_decode
  import hb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int NM_AW  = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mux,
  input  logic              fifo,
  input  logic [1:0]        mode,
  input  logic              active,
  output logic [CS_N-1:0]   cs_n
);
  logic [CS_IW-1:0] top2;
  logic [CS_IW-1:0] sel;

  assign top2 = mux ? addr[ADDR_W-1 -: CS_IW] : addr[NM_AW-1 -: CS_IW];

  always_comb begin
    if (fifo) begin
      sel = '0;
    end else begin
      case (mode)
        2'd0:    sel = '0;
        2'd1:    sel = {1'b0, top2[1]};
        default: sel = top2;
      endcase
    end
  end

  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    assign cs_n[i] = !(active && (sel == CS_IW'(i)));
  end
endmodule

// File: rtl/hb_wait_cnt.sv
module hb_wait_cnt #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WS_W-1:0] load_val,
  input  logic            en,
  output logic            done
);
  logic [WS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/hb_seq.sv
module hb_seq
  import hb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_mux,
  input  logic              cfg_ale,
  input  logic              cfg_fifo,
  input  logic [WS_W-1:0]   cfg_rd_ws,
  input  logic [WS_W-1:0]   cfg_wr_ws,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_i,
  input  logic              rdy_i,
  input  logic              xf_empty,
  input  logic              xf_full,
  input  logic              ws_done,
  output hb_state_e         state,
  output logic [ADDR_W-1:0] addr,
  output logic              wr,
  output logic [DATA_W-1:0] wd,
  output logic              ws_load,
  output logic [WS_W-1:0]   ws_val,
  output logic              wdata_take,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'(8'hFF);

  hb_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              rl_q, rl_d;
  logic [DATA_W-1:0] lane_mask;
  logic              blocked;

  assign lane_mask = cfg_wide ? '1 : NARROW_MASK;
  assign blocked   = cfg_fifo && (wr_q ? xf_full : xf_empty);
  assign ws_val    = wr_q ? cfg_wr_ws : cfg_rd_ws;

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    left_d     = left_q;
    wr_d       = wr_q;
    wd_d       = wd_q;
    rv_d       = 1'b0;
    rd_d       = rd_q;
    rl_d       = rl_q;
    ws_load    = 1'b0;
    wdata_take = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          wr_d    = req_write;
          addr_d  = req_addr;
          left_d  = req_len;
          state_d = (!cfg_fifo && (cfg_mux || cfg_ale)) ? ST_ADDR : ST_PRE;
        end
      end
      ST_ADDR: state_d = ST_PRE;
      ST_PRE: begin
        if (!blocked) begin
          state_d    = ST_STRB;
          ws_load    = 1'b1;
          wdata_take = wr_q;
          if (wr_q) wd_d = req_wdata & lane_mask;
        end
      end
      ST_STRB: begin
        if (ws_done && rdy_i) begin
          if (!wr_q) begin
            rv_d = 1'b1;
            rd_d = ad_i & lane_mask;
            rl_d = (left_q == '0);
          end
          if (left_q == '0) begin
            state_d = ST_IDLE;
          end else begin
            left_d  = left_q - 1'b1;
            addr_d  = addr_q + 1'b1;
            state_d = ST_PRE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
      rl_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      wr_q    <= wr_d;
      wd_q    <= wd_d;
      rv_q    <= rv_d;
      rd_q    <= rd_d;
      rl_q    <= rl_d;
    end
  end

  assign state     = state_q;
  assign addr      = addr_q;
  assign wr        = wr_q;
  assign wd        = wd_q;
  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign rsp_last  = rl_q;
endmodule

// File: rtl/hb_master.sv
module hb_master
  import hb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int NM_AW  = 20,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_mux,
  input  logic              cfg_ale,
  input  logic              cfg_fifo,
  input  logic [1:0]        cfg_csmode,
  input  logic [WS_W-1:0]   cfg_rd_ws,
  input  logic [WS_W-1:0]   cfg_wr_ws,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              wdata_take,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic [NM_AW-1:0]  addr_o,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ale_o,
  output logic [CS_N-1:0]   cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W/8-1:0] be_n_o,
  input  logic              rdy_i,
  input  logic              xf_empty,
  input  logic              xf_full
);
  localparam int BE_W  = DATA_W / 8;
  localparam int PAD_W = ADDR_W - DATA_W;

  logic [1:0]        sync_q;
  logic              core_rst_n;
  hb_state_e         state;
  logic [ADDR_W-1:0] addr;
  logic              wr;
  logic [DATA_W-1:0] wd;
  logic              ws_load;
  logic [WS_W-1:0]   ws_val;
  logic              ws_done;
  logic              busy;
  logic              strb;
  logic              wr_strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = sync_q[1];

  hb_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .WS_W(WS_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .cfg_wide   (cfg_wide),
    .cfg_mux    (cfg_mux),
    .cfg_ale    (cfg_ale),
    .cfg_fifo   (cfg_fifo),
    .cfg_rd_ws  (cfg_rd_ws),
    .cfg_wr_ws  (cfg_wr_ws),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_wdata  (req_wdata),
    .ad_i       (ad_i),
    .rdy_i      (rdy_i),
    .xf_empty   (xf_empty),
    .xf_full    (xf_full),
    .ws_done    (ws_done),
    .state      (state),
    .addr       (addr),
    .wr         (wr),
    .wd         (wd),
    .ws_load    (ws_load),
    .ws_val     (ws_val),
    .wdata_take (wdata_take),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_last   (rsp_last)
  );

  assign strb = (state == ST_STRB);

  hb_wait_cnt #(.WS_W(WS_W)) u_wait (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load     (ws_load),
    .load_val (ws_val),
    .en       (strb),
    .done     (ws_done)
  );

  assign busy = (state != ST_IDLE);

  hb_cs_decode #(.ADDR_W(ADDR_W), .NM_AW(NM_AW)) u_cs (
    .addr   (addr),
    .mux    (cfg_mux),
    .fifo   (cfg_fifo),
    .mode   (cfg_csmode),
    .active (busy),
    .cs_n   (cs_n_o)
  );

  assign wr_strb   = strb && wr;
  assign req_ready = core_rst_n && !busy;
  assign ale_o     = (state == ST_ADDR);
  assign rd_n_o    = !(strb && !wr);
  assign wr_n_o    = !wr_strb;
  assign ad_oe     = ale_o || wr_strb;
  assign addr_o    = (busy && !cfg_fifo && !cfg_mux) ? addr[NM_AW-1:0] : '0;

  always_comb begin
    if (ale_o) begin
      ad_o = addr;
    end else if (wr_strb) begin
      ad_o = {{PAD_W{1'b0}}, wd};
    end else begin
      ad_o = '0;
    end
  end

  always_comb begin
    if (!busy) begin
      be_n_o = '1;
    end else if (cfg_wide) begin
      be_n_o = '0;
    end else begin
      be_n_o = {{(BE_W-1){1'b1}}, 1'b0};
    end
  end
endmodule

// File: rtl/hb_master_chk.sv
module hb_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wide,
  input logic       cfg_fifo,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       ad_oe,
  input logic       ale_o,
  input logic [3:0] cs_n_o,
  input logic       rd_n_o,
  input logic       wr_n_o,
  input logic [1:0] be_n_o,
  input logic       xf_empty,
  input logic       xf_full
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n_o == 4'hF && rd_n_o && wr_n_o && !ale_o)); // R1
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o); // R2
  AST_ALE_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (rd_n_o && wr_n_o && ad_oe)); // R2
  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o)); // R4
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> ad_oe); // R7
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe); // R7
  AST_RSP_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!rd_n_o)); // R6
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o)); // R9
  AST_CS_UNDER_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o) |-> ($countones(~cs_n_o) == 1)); // R9
  AST_FIFO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fifo && $fell(rd_n_o)) |-> $past(!xf_empty)); // R10
  AST_FIFO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fifo && $fell(wr_n_o)) |-> $past(!xf_full)); // R10
  AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wide && (!rd_n_o || !wr_n_o)) |-> (be_n_o == 2'b10)); // R11
endmodule

bind hb_master hb_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wide  (cfg_wide),
  .cfg_fifo  (cfg_fifo),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ad_oe     (ad_oe),
  .ale_o     (ale_o),
  .cs_n_o    (cs_n_o),
  .rd_n_o    (rd_n_o),
  .wr_n_o    (wr_n_o),
  .be_n_o    (be_n_o),
  .xf_empty  (xf_empty),
  .xf_full   (xf_full)
);

// File: tb/hb_master_tb.sv
`timescale 1ns/1ps
module hb_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wide, cfg_mux, cfg_ale, cfg_fifo;
  logic [1:0]  cfg_csmode;
  logic [3:0]  cfg_rd_ws, cfg_wr_ws;
  logic        req_valid, req_ready, req_write;
  logic [27:0] req_addr;
  logic [3:0]  req_len;
  logic [15:0] req_wdata;
  logic        wdata_take, rsp_valid, rsp_last;
  logic [15:0] rsp_data;
  logic [19:0] addr_o;
  logic [27:0] ad_o;
  logic        ad_oe;
  logic [15:0] ad_i;
  logic        ale_o, rd_n_o, wr_n_o;
  logic [3:0]  cs_n_o;
  logic [1:0]  be_n_o;
  logic        rdy_i, xf_empty, xf_full;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  hb_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_mux(cfg_mux),
    .cfg_ale(cfg_ale), .cfg_fifo(cfg_fifo), .cfg_csmode(cfg_csmode),
    .cfg_rd_ws(cfg_rd_ws), .cfg_wr_ws(cfg_wr_ws), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .wdata_take(wdata_take),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .addr_o(addr_o), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .ale_o(ale_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .be_n_o(be_n_o), .rdy_i(rdy_i), .xf_empty(xf_empty), .xf_full(xf_full)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] memf(input logic [27:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'h31};
  endfunction

  // behavioural reference: phase 0 idle, 1 address cycle, 2 gap, 3 strobe
  int          rc = 0, ph = 0, cnt = 0, left = 0;
  logic [27:0] m_addr = '0;
  bit          m_wr = 0;
  logic [15:0] m_wd = '0, m_rd = '0;
  bit          m_rv = 0, m_rl = 0, started = 0;
  logic [27:0] bus_addr = '0;

  function automatic logic [15:0] lmask();
    return cfg_wide ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic bit m_blocked();
    return cfg_fifo && (m_wr ? xf_full : xf_empty);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n || rc < 2) begin
      if (!rst_n) rc = 0; else rc++;
      ph = 0; cnt = 0; left = 0; m_addr = '0; m_wr = 0; m_wd = '0;
      m_rv = 0; m_rd = '0; m_rl = 0;
    end else begin
      m_rv = 0;
      case (ph)
        0: if (req_valid) begin
             m_wr = req_write; m_addr = req_addr; left = int'(req_len);
             ph = (!cfg_fifo && (cfg_mux || cfg_ale)) ? 1 : 2;
           end
        1: ph = 2;
        2: if (!m_blocked()) begin
             ph = 3;
             cnt = m_wr ? int'(cfg_wr_ws) : int'(cfg_rd_ws);
             if (m_wr) m_wd = req_wdata & lmask();
           end
        default: begin
          if (cnt != 0) cnt--;
          else if (rdy_i) begin
            if (!m_wr) begin
              m_rv = 1; m_rd = memf(m_addr) & lmask(); m_rl = (left == 0);
            end
            if (left == 0) ph = 0;
            else begin left--; m_addr = m_addr + 28'd1; ph = 2; end
          end
        end
      endcase
    end
  end

  assign ad_i = memf(bus_addr);

  int ale_cnt = 0;
  always @(negedge clk) begin
    bus_addr = m_addr;
    if (ale_o) ale_cnt++;
    if (started && rst_n) begin
      logic [1:0] idx;
      logic [1:0] top2;
      logic [3:0] e_cs;
      logic [27:0] e_ad;
      top2 = cfg_mux ? m_addr[27:26] : m_addr[19:18];
      idx = cfg_fifo ? 2'd0 : (cfg_csmode == 2'd0) ? 2'd0 :
            (cfg_csmode == 2'd1) ? {1'b0, top2[1]} : top2;
      e_cs = (ph != 0) ? ~(4'b0001 << idx) : 4'hF;
      e_ad = (ph == 1) ? m_addr : (ph == 3 && m_wr) ? {12'h0, m_wd} : 28'h0;
      chk(req_ready == (rc >= 2 && ph == 0), "R1 req_ready", req_ready, (rc >= 2 && ph == 0));
      chk(ale_o == (ph == 1), "R2 ale_o", ale_o, (ph == 1));
      chk(ad_o == e_ad, "R2 R7 ad_o", ad_o, e_ad);
      chk(ad_oe == (ph == 1 || (ph == 3 && m_wr)), "R7 ad_oe", ad_oe, (ph == 1 || (ph == 3 && m_wr)));
      chk(addr_o == ((ph != 0 && !cfg_fifo && !cfg_mux) ? m_addr[19:0] : 20'h0),
          "R3 addr_o", addr_o, (ph != 0 && !cfg_fifo && !cfg_mux) ? m_addr[19:0] : 20'h0);
      chk(rd_n_o == !(ph == 3 && !m_wr), "R4 R5 rd_n_o", rd_n_o, !(ph == 3 && !m_wr));
      chk(wr_n_o == !(ph == 3 && m_wr), "R4 R5 wr_n_o", wr_n_o, !(ph == 3 && m_wr));
      chk(cs_n_o == e_cs, "R9 cs_n_o", cs_n_o, e_cs);
      chk(be_n_o == ((ph == 0) ? 2'b11 : cfg_wide ? 2'b00 : 2'b10), "R11 be_n_o",
          be_n_o, (ph == 0) ? 2'b11 : cfg_wide ? 2'b00 : 2'b10);
      chk(wdata_take == (ph == 2 && m_wr && !m_blocked()), "R7 wdata_take",
          wdata_take, (ph == 2 && m_wr && !m_blocked()));
      chk(rsp_valid == m_rv, "R6 rsp_valid", rsp_valid, m_rv);
      if (m_rv) begin
        chk(rsp_data == m_rd, "R6 R11 rsp_data", rsp_data, m_rd);
        chk(rsp_last == m_rl, "R6 rsp_last", rsp_last, m_rl);
      end
    end
  end

  // input pattern generators, driven 1 ns after the rising edge
  bit  rdy_rand = 0, flag_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit  take_s = 0;
  always @(negedge clk) take_s <= wdata_take;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy_i = rdy_rand ? (lfsr[1:0] != 2'b00) : 1'b1;
    xf_empty = flag_rand ? lfsr[3] & lfsr[5] : 1'b0;
    xf_full  = flag_rand ? lfsr[4] & lfsr[7] : 1'b0;
    if (take_s) req_wdata = req_wdata * 16'd5 + 16'h1357;
  end

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (!req_ready);
  endtask

  task automatic xfer(input bit w, input logic [27:0] a, input logic [3:0] len);
    wait_idle();
    req_valid = 1; req_write = w; req_addr = a; req_len = len;
    @(posedge clk); #1;
    req_valid = 0;
    wait_idle();
  endtask

  task automatic set_cfg(input bit wide, input bit mux, input bit ale, input bit fifo,
                         input logic [1:0] csm, input logic [3:0] rws, input logic [3:0] wws);
    wait_idle();
    cfg_wide = wide; cfg_mux = mux; cfg_ale = ale; cfg_fifo = fifo;
    cfg_csmode = csm; cfg_rd_ws = rws; cfg_wr_ws = wws;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_len = '0;
    req_wdata = 16'h1234; rdy_i = 1; xf_empty = 0; xf_full = 0;
    cfg_wide = 1; cfg_mux = 0; cfg_ale = 0; cfg_fifo = 0; cfg_csmode = 0;
    cfg_rd_ws = 4'd2; cfg_wr_ws = 4'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state at the pins
    chk(cs_n_o == 4'hF && rd_n_o && wr_n_o, "R12 strobes/selects", {cs_n_o, rd_n_o, wr_n_o}, 6'h3F);
    chk(!ale_o && !ad_oe && !req_ready, "R12 ale/oe/ready", {ale_o, ad_oe, req_ready}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(posedge clk); #1;
    chk(!req_ready, "R1 ready held during reset sync", req_ready, 0);
    @(posedge clk); #1;
    chk(req_ready, "R1 ready after sync", req_ready, 1);

    // separate address pins, single select
    xfer(1, 28'h00123, 4'd0);
    xfer(0, 28'h00123, 4'd0);
    xfer(0, 28'h00FFE, 4'd3);
    // shared pins, dual select, burst with one address cycle (R8)
    set_cfg(1, 1, 0, 0, 2'd1, 4'd1, 4'd2);
    ale_cnt = 0;
    xfer(1, 28'h8000010, 4'd2);
    chk(ale_cnt == 1, "R8 single address cycle per burst", ale_cnt, 1);
    ale_cnt = 0;
    xfer(0, 28'h8000010, 4'd5);
    chk(ale_cnt == 1, "R8 single address cycle per read burst", ale_cnt, 1);
    xfer(0, 28'h0000040, 4'd1);
    // separate pins with latch strobe, quad select (R2 R9)
    set_cfg(1, 0, 1, 0, 2'd2, 4'd0, 4'd0);
    xfer(0, 28'h80010, 4'd1);
    xfer(1, 28'hC0020, 4'd1);
    xfer(0, 28'h40030, 4'd0);
    set_cfg(1, 1, 0, 0, 2'd3, 4'd0, 4'd0);
    xfer(1, 28'hC000001, 4'd0);
    // 8-bit lane (R11)
    set_cfg(0, 0, 0, 0, 2'd0, 4'd1, 4'd1);
    xfer(1, 28'h00055, 4'd1);
    xfer(0, 28'h00A55, 4'd2);
    // ready stalls (R5), extreme wait counts (R4)
    rdy_rand = 1;
    set_cfg(1, 0, 0, 0, 2'd1, 4'd15, 4'd0);
    xfer(0, 28'h80001, 4'd2);
    xfer(1, 28'h00002, 4'd3);
    set_cfg(1, 1, 1, 0, 2'd2, 4'd3, 4'd7);
    for (int i = 0; i < 6; i++) xfer(i[0], {i[1:0], 26'h0000100} + 28'(i), 4'(i));
    rdy_rand = 0;
    // FIFO peripheral variant with flags (R10)
    flag_rand = 1;
    set_cfg(1, 1, 1, 1, 2'd2, 4'd1, 4'd1);
    xfer(0, 28'hFFFFFFF, 4'd7);
    xfer(1, 28'hFFFFFFF, 4'd7);
    set_cfg(0, 0, 0, 1, 2'd0, 4'd0, 4'd2);
    xfer(0, 28'h0, 4'd4);
    xfer(1, 28'h0, 4'd4);
    flag_rand = 0;
    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule